// File: doc/BRIEF.md
# Multi-Tile Power-Gating Sequencer

This block switches five logic tiles on and off, one at a time. Tiles 0 and 1 are processing tiles and tiles 2 to 4 are signal-processing tiles. A host writes a command word to a single command address on a simple synchronous register bus. The block decodes an opcode and a tile index from that word. It then takes the chosen tile through a timed power-down or power-up sequence, driving that tile's power-enable and isolation outputs in a safe order.

The host polls each tile's 2-bit state at its own address. A retention register records which tiles were put to sleep with their state kept, and it also carries one flag that shows that a power-down has completed. Switch settling is modelled with a counter of `SETTLE` cycles. Only one tile may be in transition at any time. A command that arrives while a transition is running is dropped, and a sticky error bit records the drop.

Top module: `tile_pwr_seq`

## Requirements
- R1: After reset every tile reads state 00, every `tile_pwr_en` bit is 1, every `tile_iso` bit is 0, and both the retention register and the error register read 0.
- R2: A write to address 0 is a command. Bits [15:8] hold the opcode and bits [7:0] hold the tile index. Opcode 0x05 requests power-down and opcode 0x06 requests power-up. Any other opcode changes nothing.
- R3: The register map is as follows. Address 1 reads the retention register in bits [5:0]. Address 2 reads the error bit in bit 0. Addresses 8 to 12 read the state of tiles 0 to 4 in bits [1:0]. State 00 means on, 10 means off and 01 means in transition. All other bits and addresses read 0.
- R4: An accepted power-down works in this order. The tile's isolation output rises, and its state reads 01, in the cycle after the command write. Its power enable falls one cycle after that. The state becomes 10 after SETTLE+1 cycles.
- R5: An accepted power-up works in this order. The tile's power enable rises, and its state reads 01, in the cycle after the command write. After SETTLE+1 cycles the state becomes 00, and the isolation output falls in that same cycle.
- R6: An accepted power-down sets the retention bit whose position equals the tile index. When the power-down completes, bit 5 is set.
- R7: A completed power-up clears the retention bit of tile 0 or tile 1. For tiles 2 to 4 the retention bits are kept. No power-up ever clears bit 5.
- R8: A power-down request to a tile that is not on is ignored. A power-up request to a tile that is on is ignored. Neither request sets the error bit.
- R9: A tile index above 4 changes no state and does not set the error bit.
- R10: Any command written while a transition is running is dropped and sets the error bit. A read of address 2 returns the error bit and clears it.
- R11: At most one tile reads state 01 at any time. No tile ever reads state 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe; clears the error bit when it reads address 2 |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| tile_pwr_en | output | 5 | Power enable, one bit per tile |
| tile_iso | output | 5 | Isolation enable, one bit per tile |

## Verification
The bench goes after the order of isolation and power at both ends of a transition. A design that cut power in the same cycle as it raised isolation, or released isolation before power was back, would show a mismatch on the per-cycle output comparison.

It probes the length of the settle window, both one cycle before the final state and at it. An off-by-one counter would report on or off a cycle early or late.

It checks how tiles differ on power-up. If a design cleared the retention bits of the signal-processing tiles, or the completion flag, the retention register would read back wrong.

It issues a second command one cycle into a transition, and sends requests that should be ignored: redundant requests, a bad index and a bad opcode. A design that queued the late command, or raised an error on an ignored request, would show a wrong state or error bit.

// File: rtl/tps_pkg.sv
package tps_pkg;
  localparam int CMD_W      = 16;
  localparam logic [7:0] OP_DOWN = 8'h05;
  localparam logic [7:0] OP_UP   = 8'h06;
  localparam int A_CMD      = 0;
  localparam int A_RET      = 1;
  localparam int A_ERR      = 2;
  localparam int A_STAT     = 8;
  localparam logic [1:0] ST_ON   = 2'b00;
  localparam logic [1:0] ST_MOVE = 2'b01;
  localparam logic [1:0] ST_OFF  = 2'b10;

  typedef enum logic [1:0] {SQ_IDLE, SQ_PREP, SQ_WAIT} seq_state_t;

  function automatic logic [7:0] cmd_op(input logic [CMD_W-1:0] w);
    return w[15:8];
  endfunction

  function automatic logic [7:0] cmd_tile(input logic [CMD_W-1:0] w);
    return w[7:0];
  endfunction
endpackage

// File: rtl/tps_decode.sv
module tps_decode
  import tps_pkg::*;
#(
  parameter int NUM_TILES = 5,
  parameter int ADDR_W    = 4,
  localparam int IDX_W    = $clog2(NUM_TILES)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [CMD_W-1:0]  wdata,
  output logic              cmd_wr,
  output logic              req_dn,
  output logic              req_up,
  output logic [IDX_W-1:0]  req_idx
);
  logic [7:0] op;
  logic [7:0] tile;
  logic       idx_ok;

  always_comb begin
    op      = cmd_op(wdata);
    tile    = cmd_tile(wdata);
    idx_ok  = (tile < 8'(NUM_TILES));
    cmd_wr  = wr && (addr == ADDR_W'(A_CMD));
    req_dn  = idx_ok && (op == OP_DOWN);
    req_up  = idx_ok && (op == OP_UP);
    req_idx = tile[IDX_W-1:0];
  end
endmodule

// File: rtl/tps_seq.sv
module tps_seq
  import tps_pkg::*;
#(
  parameter int NUM_TILES = 5,
  parameter int NUM_PROC  = 2,
  parameter int SETTLE    = 4,
  localparam int IDX_W    = $clog2(NUM_TILES),
  localparam int CNT_W    = $clog2(SETTLE + 1),
  localparam int OFF_FLAG = NUM_TILES
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_wr,
  input  logic                       req_dn,
  input  logic                       req_up,
  input  logic [IDX_W-1:0]           req_idx,
  input  logic [NUM_TILES-1:0][1:0]  tile_st,
  input  logic                       err_clr,
  output logic [NUM_TILES-1:0]       go_dn,
  output logic [NUM_TILES-1:0]       go_up,
  output logic [NUM_TILES-1:0]       cut,
  output logic [NUM_TILES-1:0]       fin_dn,
  output logic [NUM_TILES-1:0]       fin_up,
  output logic [NUM_TILES:0]         retain,
  output logic                       err,
  output logic                       busy
);
  localparam logic [NUM_TILES-1:0] ONE = NUM_TILES'(1);

  seq_state_t       state;
  logic [IDX_W-1:0] cur;
  logic             dir_dn;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       sel_st;
  logic             acc_dn, acc_up, drop, last;

  always_comb begin
    sel_st = ST_ON;
    for (int i = 0; i < NUM_TILES; i++)
      if (req_idx == IDX_W'(i)) sel_st = tile_st[i];
    busy   = (state != SQ_IDLE);
    acc_dn = cmd_wr && !busy && req_dn && (sel_st == ST_ON);
    acc_up = cmd_wr && !busy && req_up && (sel_st != ST_ON);
    drop   = cmd_wr && busy;
    last   = (state == SQ_WAIT) && (cnt == CNT_W'(SETTLE - 1));
    go_dn  = acc_dn ? (ONE << req_idx) : '0;
    go_up  = acc_up ? (ONE << req_idx) : '0;
    cut    = (state == SQ_PREP && dir_dn) ? (ONE << cur) : '0;
    fin_dn = (last && dir_dn)  ? (ONE << cur) : '0;
    fin_up = (last && !dir_dn) ? (ONE << cur) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      cur    <= '0;
      dir_dn <= 1'b0;
      cnt    <= '0;
      retain <= '0;
      err    <= 1'b0;
    end else begin
      if (drop)         err <= 1'b1;
      else if (err_clr) err <= 1'b0;
      case (state)
        SQ_IDLE: if (acc_dn || acc_up) begin
          state  <= SQ_PREP;
          cur    <= req_idx;
          dir_dn <= acc_dn;
          cnt    <= '0;
          if (acc_dn) retain[req_idx] <= 1'b1;
        end
        SQ_PREP: state <= SQ_WAIT;
        SQ_WAIT: begin
          if (last) begin
            state <= SQ_IDLE;
            if (dir_dn) retain[OFF_FLAG] <= 1'b1;
            else if (int'(cur) < NUM_PROC) retain[cur] <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R10
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(cmd_wr && busy));
  // R6
  off_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retain[OFF_FLAG]) |-> $past(state == SQ_WAIT && dir_dn));
  // R10
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (go_dn == '0 && go_up == '0));
endmodule

// File: rtl/tps_tile.sv
module tps_tile
  import tps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_dn,
  input  logic       go_up,
  input  logic       cut,
  input  logic       fin_dn,
  input  logic       fin_up,
  output logic [1:0] st,
  output logic       pwr_en,
  output logic       iso
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_ON;
      pwr_en <= 1'b1;
      iso    <= 1'b0;
    end else begin
      if (go_dn) begin
        st  <= ST_MOVE;
        iso <= 1'b1;
      end
      if (go_up) begin
        st     <= ST_MOVE;
        pwr_en <= 1'b1;
      end
      if (cut) pwr_en <= 1'b0;
      if (fin_dn) st <= ST_OFF;
      if (fin_up) begin
        st  <= ST_ON;
        iso <= 1'b0;
      end
    end
  end

  // R4
  iso_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> $past(iso));
  // R4
  cut_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iso) |=> $fell(pwr_en));
  // R5
  iso_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso) |-> pwr_en);
  // R11
  no_code11_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st != 2'b11);
endmodule

// File: rtl/tile_pwr_seq.sv
module tile_pwr_seq
  import tps_pkg::*;
#(
  parameter int NUM_TILES = 5,
  parameter int NUM_PROC  = 2,
  parameter int SETTLE    = 4,
  parameter int ADDR_W    = 4,
  localparam int IDX_W    = $clog2(NUM_TILES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [CMD_W-1:0]     bus_wdata,
  input  logic                 bus_rd,
  output logic [CMD_W-1:0]     bus_rdata,
  output logic [NUM_TILES-1:0] tile_pwr_en,
  output logic [NUM_TILES-1:0] tile_iso
);
  logic                      cmd_wr, req_dn, req_up, err, busy, err_clr;
  logic [IDX_W-1:0]          req_idx;
  logic [NUM_TILES-1:0][1:0] tile_st;
  logic [NUM_TILES-1:0]      go_dn, go_up, cut, fin_dn, fin_up, moving;
  logic [NUM_TILES:0]        retain;

  assign err_clr = bus_rd && (bus_addr == ADDR_W'(A_ERR));

  tps_decode #(.NUM_TILES(NUM_TILES), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .cmd_wr(cmd_wr), .req_dn(req_dn), .req_up(req_up), .req_idx(req_idx));

  tps_seq #(.NUM_TILES(NUM_TILES), .NUM_PROC(NUM_PROC), .SETTLE(SETTLE)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .req_dn(req_dn), .req_up(req_up),
    .req_idx(req_idx), .tile_st(tile_st), .err_clr(err_clr),
    .go_dn(go_dn), .go_up(go_up), .cut(cut), .fin_dn(fin_dn), .fin_up(fin_up),
    .retain(retain), .err(err), .busy(busy));

  for (genvar g = 0; g < NUM_TILES; g++) begin : g_tile
    tps_tile u_tile (
      .clk(clk), .rst_n(rst_n), .go_dn(go_dn[g]), .go_up(go_up[g]), .cut(cut[g]),
      .fin_dn(fin_dn[g]), .fin_up(fin_up[g]), .st(tile_st[g]),
      .pwr_en(tile_pwr_en[g]), .iso(tile_iso[g]));
    assign moving[g] = (tile_st[g] == ST_MOVE);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(A_RET)) bus_rdata[NUM_TILES:0] = retain;
    if (bus_addr == ADDR_W'(A_ERR)) bus_rdata[0] = err;
    for (int i = 0; i < NUM_TILES; i++)
      if (bus_addr == ADDR_W'(A_STAT + i)) bus_rdata[1:0] = tile_st[i];
  end

  // R11
  single_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(moving));
  // R11
  busy_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (moving != '0) |-> busy);
endmodule

// File: tb/sim_tile_pwr_seq.sv
`timescale 1ns/1ps
module sim_tile_pwr_seq;
  localparam int S = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_rdata;
  logic [4:0]  tile_pwr_en, tile_iso;

  int checks = 0, fails = 0, cyc = 0;
  bit live = 0;

  always #2.5 clk = ~clk;

  tile_pwr_seq u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tile_pwr_en(tile_pwr_en), .tile_iso(tile_iso));

  // behavioural reference
  int m_st[5], m_pwr[5], m_iso[5];
  int m_ret, m_err, m_left, m_t, m_dn;

  always @(posedge clk) begin
    int op, ix;
    bit wasb;
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) begin m_st[i] = 0; m_pwr[i] = 1; m_iso[i] = 0; end
      m_ret = 0; m_err = 0; m_left = 0; m_t = 0; m_dn = 0;
    end else begin
      wasb = (m_left > 0);
      if (wasb) begin
        m_left--;
        if (m_dn == 1 && m_left == S) m_pwr[m_t] = 0;
        if (m_left == 0) begin
          if (m_dn == 1) begin m_st[m_t] = 2; m_ret |= 32; end
          else begin
            m_st[m_t] = 0; m_iso[m_t] = 0;
            if (m_t < 2) m_ret &= ~(1 << m_t);
          end
        end
      end
      if (bus_rd && bus_addr == 2) m_err = 0;
      if (bus_wr && bus_addr == 0) begin
        if (wasb) m_err = 1;
        else begin
          op = bus_wdata >> 8; ix = bus_wdata & 255;
          if (ix < 5 && op == 5 && m_st[ix] == 0) begin
            m_st[ix] = 1; m_iso[ix] = 1; m_ret |= (1 << ix);
            m_left = S + 1; m_t = ix; m_dn = 1;
          end else if (ix < 5 && op == 6 && m_st[ix] != 0) begin
            m_st[ix] = 1; m_pwr[ix] = 1;
            m_left = S + 1; m_t = ix; m_dn = 0;
          end
        end
      end
    end
  end

  function automatic int exp_rd(input int a);
    if (a == 1) return m_ret;
    if (a == 2) return m_err;
    if (a >= 8 && a < 13) return m_st[a-8];
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    #1;
    if (live) begin
      int ep, ei;
      ep = 0; ei = 0;
      for (int i = 0; i < 5; i++) begin ep |= m_pwr[i] << i; ei |= m_iso[i] << i; end
      chk(int'(tile_pwr_en) == ep, "R4 R5 power enable", tile_pwr_en, ep);
      chk(int'(tile_iso) == ei, "R4 R5 isolation", tile_iso, ei);
      chk(int'(bus_rdata) == exp_rd(int'(bus_addr)), "R3 read data", bus_rdata, exp_rd(int'(bus_addr)));
    end
  end

  task automatic cmd(input logic [15:0] w);
    @(negedge clk); bus_addr = 0; bus_wdata = w; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); bus_addr = 4'(a); bus_rd = 1; #0.5; v = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic peek(input int a, output int v);
    bus_addr = 4'(a); #0.5; v = bus_rdata;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1; live = 1;
    // R1
    rd(1, v); chk(v == 0, "R1 retention", v, 0);
    rd(2, v); chk(v == 0, "R1 error", v, 0);
    for (int i = 0; i < 5; i++) begin peek(8 + i, v); chk(v == 0, "R1 state", v, 0); end
    chk(tile_pwr_en == 5'h1f && tile_iso == 0, "R1 outputs", {tile_pwr_en, tile_iso}, 10'h3e0);
    // R4 power-down of tile 3
    cmd(16'h0503);
    peek(11, v); chk(v == 1, "R4 moving state", v, 1);
    chk(tile_iso[3] && tile_pwr_en[3], "R4 iso before cut", {tile_iso[3], tile_pwr_en[3]}, 3);
    step(1); chk(!tile_pwr_en[3], "R4 power cut", tile_pwr_en[3], 0);
    peek(10, v); chk(v == 0, "R11 other tile", v, 0);
    step(S - 1); peek(11, v); chk(v == 1, "R4 still settling", v, 1);
    step(1); peek(11, v); chk(v == 2, "R4 off", v, 2);
    rd(1, v); chk(v == 'h28, "R6 retention", v, 'h28);
    // R5 power-up of tile 3
    cmd(16'h0603);
    chk(tile_pwr_en[3] && tile_iso[3], "R5 power first", {tile_pwr_en[3], tile_iso[3]}, 3);
    step(S); peek(11, v); chk(v == 1, "R5 still settling", v, 1);
    step(1); peek(11, v); chk(v == 0 && !tile_iso[3], "R5 on", v, 0);
    rd(1, v); chk(v == 'h28, "R7 dsp retain kept", v, 'h28);
    // R7 processing tile clears its bit
    cmd(16'h0500); step(S + 1);
    rd(1, v); chk(v == 'h29, "R6 tile0 bit", v, 'h29);
    cmd(16'h0600); step(S + 1);
    rd(1, v); chk(v == 'h28, "R7 tile0 cleared", v, 'h28);
    // R8 redundant requests
    cmd(16'h0501); step(S + 1);
    cmd(16'h0501); step(2);
    peek(9, v); chk(v == 2, "R8 down on off tile", v, 2);
    cmd(16'h0602); step(2);
    peek(10, v); chk(v == 0 && tile_pwr_en[2], "R8 up on on tile", v, 0);
    rd(2, v); chk(v == 0, "R8 no error", v, 0);
    // R9 bad index
    cmd(16'h0507); step(2);
    rd(1, v); chk(v == 'h2a, "R9 retention unchanged", v, 'h2a);
    rd(2, v); chk(v == 0, "R9 no error", v, 0);
    // R2 unknown opcode
    cmd(16'h0702); step(2);
    peek(10, v); chk(v == 0 && tile_pwr_en == 5'b11101, "R2 unknown opcode", v, 0);
    // R10 command while busy
    cmd(16'h0504); cmd(16'h0502);
    rd(2, v); chk(v == 1, "R10 error set", v, 1);
    peek(10, v); chk(v == 0, "R10 dropped", v, 0);
    rd(2, v); chk(v == 0, "R10 cleared by read", v, 0);
    step(S + 2); peek(12, v); chk(v == 2, "R10 first completes", v, 2);
    cmd(16'h0601); step(S + 2);
    peek(9, v); chk(v == 0, "R5 tile1 on", v, 0);
    live = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule